// File: doc/BRIEF.md
# Multifunction Port Pin Alternate-Function Mux

This block is one 8-bit bidirectional port of a microcontroller-style chip. Each pin has a storage bit (the latch), an output driver and an input buffer. Software writes the latch through a masked byte write. The synchronised pin levels are always readable as a byte.

On top of the plain port, the mux lays alternate functions onto single pins:
- **Pins 0 and 1** carry a serial link. A serial-mode bit picks the arrangement. With mode 0 (shared), pin 0 is a direction output and pin 1 is a two-way data pin. With mode 1 (loop), pin 0 is receive-data and pin 1 is transmit-data.
- **Diagnostic mode** is entered by clearing latch bit 1. In this mode pin 0 becomes the receive input whatever the serial mode.
- **Pins 2 and 3** feed the two interrupt/counter-gate inputs.
- **Pins 4 and 5** feed the two timer count inputs. Pin 5 also feeds the serial clock.
- **Pin 6** carries the active-low external write strobe.

An alternate output only reaches its pin while that pin's latch bit is 1. A latch bit of 0 always pulls the pin low.

The timer, interrupt and serial engines are outside this block. They connect through the alternate-function inputs and the routed, synchronised outputs.

Top module: `mpx_port`

## Requirements
- R1: After reset every latch bit is 1, no pin is driven (`pin_oe` = 0x00), `pin_out` reads 0xFF, and with all pins high the routed inputs read 1.
- R2: A write with `wr_en` = 1 loads `wr_data` into the latch bits whose `wr_mask` bit is 1 and leaves the other bits unchanged. The new value acts on the pins from the cycle after the write edge.
- R3: A pin whose latch bit is 0 has `pin_oe` = 1 and `pin_out` = 0, whatever alternate function is active on it.
- R4: A pin whose latch bit is 1 and which has no active alternate output has `pin_oe` = 0 and `pin_out` = 1.
- R5: `port_rd` equals `pin_in` as it was two clock edges earlier. After only one edge it still shows the older value.
- R6: With `ser_mode` = 0 and diagnostic mode off:
  - while `ser_act` = 1, pin 0 is driven with `ser_dir`;
  - pin 1 is driven with `ser_dout` only while `ser_dout_oe` = 1;
  - `ser_rx` follows synchronised pin 1.
- R7: With `ser_mode` = 1, pin 0 is never driven by the serial function. While `ser_act` = 1, pin 1 is driven with `ser_dout`. `ser_rx` follows synchronised pin 0.
- R8: `diag_mode` is 1 exactly when latch bit 1 is 0. In that state pin 0 is not driven by the serial function and `ser_rx` follows synchronised pin 0, even with `ser_mode` = 0.
- R9: `irq_gate[0]` and `irq_gate[1]` are synchronised pins 2 and 3.
- R10: `tmr_cnt[0]` and `tmr_cnt[1]` are synchronised pins 4 and 5, and `ser_clk` is also synchronised pin 5.
- R11: While `xwr_act` = 1, pin 6 is driven (`pin_oe[6]` = 1) with latch bit 6 AND `xwr_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Latch write enable |
| wr_mask | input | 8 | Per-bit write mask |
| wr_data | input | 8 | Latch write data |
| ser_mode | input | 1 | 0: shared direction/data, 1: loop receive/transmit |
| ser_act | input | 1 | Serial unit owns its output pins |
| ser_dir | input | 1 | Direction value for pin 0 in shared mode |
| ser_dout | input | 1 | Serial data/transmit value for pin 1 |
| ser_dout_oe | input | 1 | Pin 1 drive enable in shared mode |
| xwr_act | input | 1 | External data write cycle in progress |
| xwr_n | input | 1 | Active-low write strobe value |
| pin_in | input | 8 | Levels seen at the pins |
| pin_out | output | 8 | Pin drive values |
| pin_oe | output | 8 | Pin drive enables |
| port_rd | output | 8 | Synchronised pin levels |
| irq_gate | output | 2 | Interrupt/counter-gate inputs (pins 2, 3) |
| tmr_cnt | output | 2 | Timer count inputs (pins 4, 5) |
| ser_clk | output | 1 | External serial clock (pin 5) |
| ser_rx | output | 1 | Serial receive input |
| diag_mode | output | 1 | Diagnostic mode active |

## Verification
A latch write and the write strobe can land on pin 6 in the same cycle. The bench provokes this by clearing latch bit 6 while `xwr_act` is high with `xwr_n` at 1. From the next cycle the pin must be driven low: the latch wins over the idle-high strobe.

A second collision uses pins 0 and 1. Latch bit 1 is cleared while the serial unit is active in shared mode. The checks then show three things at once: pin 1 is pulled low by the latch, pin 0 is released, and `ser_rx` switches to pin 0.

// File: rtl/mpx_pkg.sv
package mpx_pkg;

    localparam int PORT_W    = 8;
    localparam int PIN_SDIR  = 0;
    localparam int PIN_SDATA = 1;
    localparam int PIN_IRQ0  = 2;
    localparam int PIN_TMR0  = 4;
    localparam int PIN_TMR1  = 5;
    localparam int PIN_XWR   = 6;

    typedef enum logic {
        SER_SHARED = 1'b0,
        SER_LOOP   = 1'b1
    } ser_mode_e;

    // Alternate-function drive request per pin
    typedef struct packed {
        logic [PORT_W-1:0] en;
        logic [PORT_W-1:0] val;
    } pin_drive_t;

    // Routed, synchronised alternate inputs
    typedef struct packed {
        logic [1:0] irq;
        logic [1:0] tcnt;
        logic       sclk;
        logic       rxd;
    } alt_in_t;

    // {oe, out} for one pin from latch bit and alternate request
    function automatic logic [1:0] pin_resolve(input logic latch_bit,
                                               input logic alt_en,
                                               input logic alt_val);
        logic oe;
        logic val;
        oe  = ~latch_bit | alt_en;
        val = latch_bit & (alt_en ? alt_val : 1'b1);
        return {oe, val};
    endfunction

endpackage

// File: rtl/mpx_latch_bank.sv
module mpx_latch_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_mask,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] latch_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '1;
        end else if (wr_en) begin
            latch_q <= (latch_q & ~wr_mask) | (wr_data & wr_mask);
        end
    end

    // R1: reset leaves every latch bit high
    a_r1_latch_reset: assert property (@(posedge clk)
        $fell(rst) |-> latch_q == '1);

    // R2: unmasked bits hold their value across a write
    a_r2_mask_keeps: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((latch_q ^ $past(latch_q)) & ~$past(wr_mask)) == '0);

endmodule

// File: rtl/mpx_in_sync.sv
module mpx_in_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '1;
        end else begin
            stg[0] <= pin_i;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign sync_o = stg[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk2
            logic [1:0] age;
            always_ff @(posedge clk) begin
                if (rst)             age <= '0;
                else if (age != 2'd2) age <= age + 2'd1;
            end
            // R5: two-edge latency from pin to read value
            a_r5_two_edge_latency: assert property (@(posedge clk) disable iff (rst)
                age == 2'd2 |-> sync_o == $past(pin_i, 2));
        end
    endgenerate

endmodule

// File: rtl/mpx_alt_mux.sv
module mpx_alt_mux
    import mpx_pkg::*;
(
    input  logic [PORT_W-1:0] latch_q,
    input  ser_mode_e         ser_mode,
    input  logic              ser_act,
    input  logic              ser_dir,
    input  logic              ser_dout,
    input  logic              ser_dout_oe,
    input  logic              xwr_act,
    input  logic              xwr_n,
    input  logic [5:0]        sync_i,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe,
    output alt_in_t           alt_in,
    output logic              diag
);

    pin_drive_t drv;
    logic       loop_sel;

    assign diag     = ~latch_q[PIN_SDATA];
    assign loop_sel = (ser_mode == SER_LOOP);

    always_comb begin
        drv.en  = '0;
        drv.val = '1;
        // pin 0: direction output only in shared mode outside diagnostics
        if (!loop_sel && !diag && ser_act) begin
            drv.en[PIN_SDIR]  = 1'b1;
            drv.val[PIN_SDIR] = ser_dir;
        end
        // pin 1: transmit in loop mode, gated two-way data in shared mode
        if (ser_act && (loop_sel || ser_dout_oe)) begin
            drv.en[PIN_SDATA]  = 1'b1;
            drv.val[PIN_SDATA] = ser_dout;
        end
        // pin 6: external write strobe
        if (xwr_act) begin
            drv.en[PIN_XWR]  = 1'b1;
            drv.val[PIN_XWR] = xwr_n;
        end
    end

    generate
        for (genvar i = 0; i < PORT_W; i++) begin : g_pin
            logic [1:0] res;
            assign res        = pin_resolve(latch_q[i], drv.en[i], drv.val[i]);
            assign pin_oe[i]  = res[1];
            assign pin_out[i] = res[0];
        end
    endgenerate

    always_comb begin
        alt_in.irq  = sync_i[PIN_IRQ0+1:PIN_IRQ0];
        alt_in.tcnt = sync_i[PIN_TMR1:PIN_TMR0];
        alt_in.sclk = sync_i[PIN_TMR1];
        alt_in.rxd  = (loop_sel || diag) ? sync_i[PIN_SDIR] : sync_i[PIN_SDATA];
    end

endmodule

// File: rtl/mpx_port.sv
module mpx_port
    import mpx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_mask,
    input  logic [PORT_W-1:0] wr_data,
    input  logic              ser_mode,
    input  logic              ser_act,
    input  logic              ser_dir,
    input  logic              ser_dout,
    input  logic              ser_dout_oe,
    input  logic              xwr_act,
    input  logic              xwr_n,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe,
    output logic [PORT_W-1:0] port_rd,
    output logic [1:0]        irq_gate,
    output logic [1:0]        tmr_cnt,
    output logic              ser_clk,
    output logic              ser_rx,
    output logic              diag_mode
);

    logic [PORT_W-1:0] latch_q;
    logic [PORT_W-1:0] sync_q;
    alt_in_t           alt_in;

    mpx_latch_bank #(.W(PORT_W)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_mask (wr_mask),
        .wr_data (wr_data),
        .latch_q (latch_q)
    );

    mpx_in_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (pin_in),
        .sync_o (sync_q)
    );

    mpx_alt_mux u_mux (
        .latch_q     (latch_q),
        .ser_mode    (ser_mode_e'(ser_mode)),
        .ser_act     (ser_act),
        .ser_dir     (ser_dir),
        .ser_dout    (ser_dout),
        .ser_dout_oe (ser_dout_oe),
        .xwr_act     (xwr_act),
        .xwr_n       (xwr_n),
        .sync_i      (sync_q[5:0]),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe),
        .alt_in      (alt_in),
        .diag        (diag_mode)
    );

    assign port_rd  = sync_q;
    assign irq_gate = alt_in.irq;
    assign tmr_cnt  = alt_in.tcnt;
    assign ser_clk  = alt_in.sclk;
    assign ser_rx   = alt_in.rxd;

    generate
        for (genvar i = 0; i < PORT_W; i++) begin : g_chk
            // R3: a cleared latch bit always pulls its pin low
            a_r3_low_latch_drives_low: assert property (@(posedge clk) disable iff (rst)
                !latch_q[i] |-> (pin_oe[i] && !pin_out[i]));
        end
    endgenerate

    // R7: loop mode never drives pin 0 while its latch bit is high
    a_r7_loop_pin0_free: assert property (@(posedge clk) disable iff (rst)
        (ser_mode && latch_q[PIN_SDIR]) |-> !pin_oe[PIN_SDIR]);

    // R8: diagnostic mode releases pin 0 and takes receive data from it
    a_r8_diag_pin0_free: assert property (@(posedge clk) disable iff (rst)
        (diag_mode && latch_q[PIN_SDIR]) |-> (!pin_oe[PIN_SDIR] && ser_rx == port_rd[PIN_SDIR]));

    // R11: an active strobe pulls pin 6 low
    a_r11_strobe_low: assert property (@(posedge clk) disable iff (rst)
        (xwr_act && !xwr_n) |-> (pin_oe[PIN_XWR] && !pin_out[PIN_XWR]));

endmodule

// File: tb/tb_mpx_port.sv
module tb_mpx_port;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wr_mask, wr_data;
    logic       ser_mode, ser_act, ser_dir, ser_dout, ser_dout_oe;
    logic       xwr_act, xwr_n;
    logic [7:0] pin_in;
    logic [7:0] pin_out, pin_oe, port_rd;
    logic [1:0] irq_gate, tmr_cnt;
    logic       ser_clk, ser_rx, diag_mode;

    always #5 clk = ~clk;

    mpx_port dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_mask(wr_mask), .wr_data(wr_data),
        .ser_mode(ser_mode), .ser_act(ser_act), .ser_dir(ser_dir), .ser_dout(ser_dout),
        .ser_dout_oe(ser_dout_oe), .xwr_act(xwr_act), .xwr_n(xwr_n), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .port_rd(port_rd), .irq_gate(irq_gate),
        .tmr_cnt(tmr_cnt), .ser_clk(ser_clk), .ser_rx(ser_rx), .diag_mode(diag_mode)
    );

    // sel: 0 pin_out, 1 pin_oe, 2 port_rd,
    //      3 {diag, ser_rx, ser_clk, tmr_cnt[1:0], irq_gate[1:0]}
    typedef struct {
        string      req;
        int         sel;
        logic [7:0] exp;
    } item_t;

    item_t q[$];
    int    n_vec  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    function automatic logic [7:0] observe(int sel);
        case (sel)
            0:       return pin_out;
            1:       return pin_oe;
            2:       return port_rd;
            default: return {1'b0, diag_mode, ser_rx, ser_clk, tmr_cnt, irq_gate};
        endcase
    endfunction

    // monitor: compares queued expectations at the falling edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it  = q.pop_front();
            act = observe(it.sel);
            n_vec++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s sel=%0d actual=%02h expected=%02h", it.req, it.sel, act, it.exp);
            end
        end
    end

    task automatic expect_v(string req, int sel, logic [7:0] exp);
        item_t it;
        it.req = req; it.sel = sel; it.exp = exp;
        q.push_back(it);
        wait (q.size() == 0);
        #1;
    endtask

    task automatic latch_write(logic [7:0] m, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_mask = m; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    // pins settle through both synchroniser stages
    task automatic set_pins(logic [7:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (2) @(negedge clk);
        #1;
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_mask = '0; wr_data = '0;
        ser_mode = 1'b0; ser_act = 1'b0; ser_dir = 1'b0; ser_dout = 1'b0; ser_dout_oe = 1'b0;
        xwr_act = 1'b0; xwr_n = 1'b1; pin_in = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;

        // R1 reset state
        expect_v("R1", 1, 8'h00);
        expect_v("R1", 0, 8'hFF);
        expect_v("R1", 2, 8'hFF);
        expect_v("R1", 3, 8'h3F);
        // R4 idle pin 7 undriven
        expect_v("R4", 1, 8'h00);

        // R2 masked writes, R3 low bits driven low
        latch_write(8'h0F, 8'h05);
        expect_v("R2", 0, 8'hF5);
        expect_v("R3", 1, 8'h0A);
        latch_write(8'hF0, 8'hA0);
        expect_v("R2", 0, 8'hA5);
        expect_v("R3", 1, 8'h5A);
        expect_v("R8", 3, 8'h7F);
        latch_write(8'hFF, 8'hFF);
        expect_v("R4", 1, 8'h00);

        // R5 two-edge latency
        @(negedge clk);
        pin_in = 8'h3C;
        #1;
        expect_v("R5", 2, 8'hFF);
        expect_v("R5", 2, 8'h3C);
        expect_v("R9", 3, 8'h1F);

        // R6 shared mode
        ser_mode = 1'b0; ser_act = 1'b1; ser_dir = 1'b0; ser_dout = 1'b0; ser_dout_oe = 1'b1;
        #1;
        expect_v("R6", 1, 8'h03);
        expect_v("R6", 0, 8'hFC);
        ser_dout_oe = 1'b0; #1;
        expect_v("R6", 1, 8'h01);
        expect_v("R6", 0, 8'hFE);
        ser_dir = 1'b1; #1;
        expect_v("R6", 0, 8'hFF);

        // R7 loop mode
        ser_mode = 1'b1; ser_dout = 1'b0; #1;
        expect_v("R7", 1, 8'h02);
        expect_v("R7", 0, 8'hFD);
        set_pins(8'h01);
        expect_v("R7", 3, 8'h20);
        ser_mode = 1'b0; ser_dout_oe = 1'b0; #1;
        expect_v("R6", 3, 8'h00);

        // R8 diagnostic mode with serial active in shared mode
        ser_dir = 1'b0;
        latch_write(8'h02, 8'h00);
        expect_v("R8", 1, 8'h02);
        expect_v("R8", 0, 8'hFD);
        expect_v("R8", 3, 8'h60);
        latch_write(8'h02, 8'h02);
        expect_v("R8", 3, 8'h00);
        ser_act = 1'b0; #1;

        // R11 write strobe, plus latch clear in the same cycle
        xwr_act = 1'b1; xwr_n = 1'b0; #1;
        expect_v("R11", 1, 8'h40);
        expect_v("R11", 0, 8'hBF);
        xwr_n = 1'b1; #1;
        expect_v("R11", 0, 8'hFF);
        latch_write(8'h40, 8'h00);
        expect_v("R11", 0, 8'hBF);
        expect_v("R3", 1, 8'h40);
        xwr_act = 1'b0; #1;
        expect_v("R3", 1, 8'h40);
        latch_write(8'h40, 8'h40);
        expect_v("R4", 1, 8'h00);

        // R10 timer and serial clock, R9 interrupts
        set_pins(8'h20);
        expect_v("R10", 3, 8'h18);
        set_pins(8'h10);
        expect_v("R10", 3, 8'h04);
        set_pins(8'h04);
        expect_v("R9", 3, 8'h01);
        set_pins(8'h08);
        expect_v("R9", 3, 8'h02);

        done = 1'b1;
        finish_run();
    end

endmodule